// File: doc/BRIEF.md
# Miller Clamp Latch Controller

This controller decides when the active Miller clamp switch of a gate driver is closed. It watches two inputs. The first is the gate command. The second is a comparator bit that reports whether the sensed gate voltage, measured against the secondary-side ground, sits below a fixed reference of about 2 V. The comparator bit arrives from the analog domain, so it is brought onto the clock through a flop synchronizer before any decision uses it.

When the command falls, the controller arms with the clamp open. It then waits for the synchronized comparator to report that the gate has dropped below the reference. At that point it latches the clamp closed, which gives the gate a second low-impedance discharge path. The clamp then stays closed for the rest of the off period, whatever the comparator does afterwards. A rising command edge releases it and returns the controller to idle, ready for the next turn-off.

Top module: `millerClampCtrl`

## Requirements
- R1: While `rstN` is low, and directly after it is released with `gateCmd` high, `clampOn` is 0.
- R2: `clampOn` is 0 in every cycle in which `gateCmd` is 1, including the cycle in which `gateCmd` has just risen while the clamp was latched.
- R3: After `gateCmd` falls, `clampOn` stays 0 as long as the comparator bit `gateBelowRef` (1 = gate voltage below reference) remains 0.
- R4: With `gateCmd` held low and the controller armed, a `gateBelowRef` value of 1 first sampled at clock edge E1 makes `clampOn` 1 after edge E3. The delay is two synchronizer flops plus the latch.
- R5: Once latched, the clamp stays on while `gateCmd` stays low, even if `gateBelowRef` returns to 0.
- R6: A low-to-high edge of `gateCmd` releases the clamp. The next off period starts again with the clamp open until a new below-reference indication arrives.
- R7: A `gateBelowRef` of 1 while `gateCmd` is high does not close the clamp. If the bit is still 1 when `gateCmd` falls at edge F1, `clampOn` becomes 1 after edge F2.
- R8: If the synchronized below-reference indication and a high `gateCmd` fall in the same cycle, the release wins. The clamp stays open, and no stale latch shows up in the following off period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gateCmd | input | 1 | Gate command, 1 = switch on, synchronous to clk |
| gateBelowRef | input | 1 | Asynchronous comparator bit, 1 = sensed gate voltage below reference |
| clampOn | output | 1 | Miller clamp switch drive, 1 = closed |

## Verification
Two functions of this block can land in the same cycle: latching the clamp, triggered when the synchronized comparator indication arrives, and releasing it, triggered when the command rises. The bench provokes this by raising `gateBelowRef` during an armed off period and then raising `gateCmd` exactly in the cycle in which the synchronizer output turns 1. It judges the outcome by requiring `clampOn` to stay 0 in that cycle, after the edge, and through a following off period in which the comparator stays high-voltage.

// File: rtl/millerClampPkg.sv
package millerClampPkg;

  typedef enum logic [1:0] {
    CL_IDLE    = 2'd0,
    CL_ARMED   = 2'd1,
    CL_LATCHED = 2'd2
  } clampState_e;

  typedef struct packed {
    logic setClamp;
    logic clearClamp;
  } clampStrobe_t;

endpackage

// File: rtl/millerSync.sv
module millerSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] syncQ;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= asyncIn;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[STAGES-1];

endmodule

// File: rtl/millerCtrl.sv
module millerCtrl
  import millerClampPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdIn,
  input  logic         belowSync,
  output clampStrobe_t strobe
);

  clampState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (cmdIn) begin
      stateNext = CL_IDLE;
    end else begin
      unique case (state)
        CL_IDLE:    stateNext = CL_ARMED;
        CL_ARMED:   if (belowSync) stateNext = CL_LATCHED;
        CL_LATCHED: stateNext = CL_LATCHED;
        default:    stateNext = CL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CL_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.setClamp   = (state == CL_ARMED) && !cmdIn && belowSync;
    strobe.clearClamp = cmdIn;
  end

  AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == CL_IDLE && !cmdIn) |=> (state == CL_ARMED)); // R3

  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == CL_LATCHED && !cmdIn) |=> (state == CL_LATCHED)); // R5

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> (state == CL_IDLE)); // R6

  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == CL_ARMED && !cmdIn && !belowSync) |=> (state == CL_ARMED)); // R3

endmodule

// File: rtl/millerDp.sv
module millerDp
  import millerClampPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdIn,
  input  clampStrobe_t strobe,
  output logic         clampOut
);

  logic clampQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 clampQ <= 1'b0;
    else if (strobe.clearClamp) clampQ <= 1'b0;
    else if (strobe.setClamp)   clampQ <= 1'b1;
  end

  assign clampOut = clampQ && !cmdIn;

  AST_NO_SET_AND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setClamp && strobe.clearClamp)); // R8

  AST_CLAMP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (clampQ && !cmdIn) |=> clampQ); // R5

  AST_CLAMP_NEEDS_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampQ) |-> $past(strobe.setClamp)); // R4

  AST_CLEAR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> !clampQ); // R6

endmodule

// File: rtl/millerClampCtrl.sv
module millerClampCtrl
  import millerClampPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateCmd,
  input  logic gateBelowRef,
  output logic clampOn
);

  logic         belowSync;
  clampStrobe_t strobe;

  millerSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (gateBelowRef),
    .syncOut (belowSync)
  );

  millerCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdIn     (gateCmd),
    .belowSync (belowSync),
    .strobe    (strobe)
  );

  millerDp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdIn    (gateCmd),
    .strobe   (strobe),
    .clampOut (clampOn)
  );

  AST_OFF_IN_RESET: assert property (@(posedge clk) !rstN |-> !clampOn); // R1

endmodule

// File: tb/millerClampCtrl_tb_top.sv
`timescale 1ns/1ps
module millerClampCtrl_tb_top;

  typedef struct {
    logic  expVal;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateCmd = 1'b1;
  logic gateBelowRef = 1'b0;
  logic clampOn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  millerClampCtrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .gateCmd      (gateCmd),
    .gateBelowRef (gateBelowRef),
    .clampOn      (clampOn)
  );

  task automatic compare(input logic expVal, input string tag);
    checks++;
    if (clampOn !== expVal) begin
      fails++;
      $display("FAIL %s clampOn=%0b expected %0b at %0t", tag, clampOn, expVal, $time);
    end
  endtask

  // driver: new inputs just after an edge, expected output for that cycle queued
  task automatic step(input logic cmd, input logic below, input logic expVal, input string tag);
    expItem_t item;
    @(posedge clk);
    #1;
    gateCmd = cmd;
    gateBelowRef = below;
    item.expVal = expVal;
    item.tag = tag;
    expQ.push_back(item);
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t item;
        item = expQ.pop_front();
        compare(item.expVal, item.tag);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;

    step(1, 0, 0, "R1 after reset");
    step(1, 0, 0, "R2 command high");
    // normal turn-off, comparator crossing, latency
    step(0, 0, 0, "R3 first low cycle");
    step(0, 0, 0, "R3 armed waiting");
    step(0, 0, 0, "R3 armed waiting");
    step(0, 1, 0, "R4 crossing applied");
    step(0, 1, 0, "R4 after E1");
    step(0, 1, 0, "R4 after E2");
    step(0, 1, 1, "R4 after E3 latched");
    // comparator glitch back above reference
    step(0, 0, 1, "R5 glitch hold");
    step(0, 0, 1, "R5 glitch hold");
    step(0, 1, 1, "R5 hold");
    step(0, 0, 1, "R5 hold");
    step(0, 0, 1, "R5 hold");
    // release
    step(1, 0, 0, "R2 rising edge cycle");
    step(1, 0, 0, "R6 released");
    step(0, 0, 0, "R6 rearmed open");
    step(0, 0, 0, "R6 rearmed open");
    step(0, 0, 0, "R6 rearmed open");
    step(1, 0, 0, "R2 high again");
    // comparator already low while command high
    step(1, 1, 0, "R7 below while high");
    step(1, 1, 0, "R7 below while high");
    step(1, 1, 0, "R7 below while high");
    step(0, 1, 0, "R7 fall F1 pending");
    step(0, 1, 0, "R7 after F1");
    step(0, 1, 1, "R7 after F2 latched");
    step(1, 1, 0, "R2 release");
    step(1, 0, 0, "R6 idle");
    // coincidence: synchronized arrival with rising command
    step(0, 0, 0, "R8 setup");
    step(0, 0, 0, "R8 setup");
    step(0, 0, 0, "R8 setup");
    step(0, 1, 0, "R8 crossing applied");
    step(0, 1, 0, "R8 after E1");
    step(1, 1, 0, "R8 coincident cycle");
    step(1, 0, 0, "R8 release won");
    step(1, 0, 0, "R8 idle");
    step(0, 0, 0, "R8 no stale latch");
    step(0, 0, 0, "R8 no stale latch");
    step(0, 0, 0, "R8 no stale latch");
    step(0, 0, 0, "R8 no stale latch");
    step(1, 0, 0, "R2 end");

    wait (expQ.size() == 0);
    @(negedge clk);
    @(negedge clk);
    finish();
  end

endmodule